// File: doc/BRIEF.md
# Grouped Five-Channel Counter Synchronizer

This block holds five 16-bit up-counters and a control set that lets any of them join a shared group. Each counter counts on its own count-enable input. Software reaches the counters, an 8-bit group-membership register and a per-channel 3-bit clear-select field through a simple register bus. The bus has one write port and a combinational read port.

A channel outside the group is fully independent. A channel inside the group shares two actions with every other member. A software write to any member's counter loads the written value into all members on the same clock edge. A clear event on a member that has a clear source selected zeroes every member. The group exists only while at least two channels are enrolled. A lone enrolled channel behaves as if it were independent.

Top module: `timer_sync_group`

## Requirements
- R1: After synchronous reset, all five counters, the membership register and every clear-select field read as zero.
- R2: The membership register sits at address 5. Channels 0, 1 and 2 enroll through bits 0, 1 and 2, channel 3 through bit 6 and channel 4 through bit 7. Bits 5:3 always read 0 and ignore written data, so writing 8'hFF reads back 8'hC7.
- R3: A counter with its count-enable high and no clear or load pending increments by one. From 16'hFFFF it wraps to 16'h0000.
- R4: A channel whose membership bit is 0 is touched only by its own write, own clear and own count. Loads and clears on other channels leave it unchanged.
- R5: While the group is formed, a write to any member's counter address loads the written value into every member counter on that clock edge.
- R6: While the group is formed, a clear event on a member whose clear-select is nonzero zeroes every member counter on that edge, including members whose clear-select is 3'b000.
- R7: A clear-select of 3'b000 makes that channel's own clear-event input have no effect on its counter. Any nonzero value makes the clear event zero its own counter.
- R8: The group is formed only when two or more membership bits are set. With exactly one bit set, that channel behaves as in R4.
- R9: Within one edge, a clear takes precedence over a load, and a load takes precedence over an increment.
- R10: The address map is fixed. Counters 0 to 4 sit at addresses 0 to 4. The clear-select of channel i sits at address 6+i in bits 2:0, and unused read bits return 0. Counter values are read back on `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Combinational read data |
| cnt_en | input | 5 | Per-channel count enable |
| clr_evt | input | 5 | Per-channel clear event |

## Verification
The hardest case to reach is a clear event that spreads through the group in the same edge as a counter load and increments on other channels. On that edge each member has to resolve three competing commands coming from different channels. The random phase enrolls channels, programs clear-selects, writes counters and fires clear events all at once over thousands of cycles, and a bench model tracks every counter. Directed steps then pin down a lone enrolled channel, a clear spread to a member with clear-select zero, clear against load on one channel, and wrap-around.

// File: rtl/tgs_pkg.sv
package tgs_pkg;

    localparam int NUM_CH  = 5;
    localparam int SYNC_W  = 8;
    localparam int ADDR_W  = 4;
    localparam int ADDR_SYNC = NUM_CH;
    localparam int ADDR_SEL0 = NUM_CH + 1;

    // Per-channel command resolved by the group logic.
    typedef struct packed {
        logic clr;
        logic ld;
        logic inc;
    } cnt_cmd_t;

    // Bit position of a channel's membership flag.
    function automatic int unsigned sync_pos(input int unsigned ch);
        return (ch < 3) ? ch : ch + 3;
    endfunction

    function automatic logic [SYNC_W-1:0] sync_wmask();
        logic [SYNC_W-1:0] m;
        m = '0;
        for (int unsigned c = 0; c < NUM_CH; c++) m[sync_pos(c)] = 1'b1;
        return m;
    endfunction

    localparam logic [SYNC_W-1:0] SYNC_MASK = sync_wmask();

endpackage

// File: rtl/tgs_regs.sv
module tgs_regs
    import tgs_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SEL_W  = 3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [SYNC_W-1:0]            sync_reg,
    output logic [NUM_CH-1:0][SEL_W-1:0] sel_reg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_reg <= '0;
        end else if (wr_en && (wr_addr == ADDR_W'(ADDR_SYNC))) begin
            sync_reg <= wr_data[SYNC_W-1:0] & SYNC_MASK;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
        always_ff @(posedge clk) begin
            if (rst) begin
                sel_reg[c] <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(ADDR_SEL0 + c))) begin
                sel_reg[c] <= wr_data[SEL_W-1:0];
            end
        end
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (sync_reg & ~SYNC_MASK) == '0);  // R2

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (sync_reg == '0 && sel_reg == '0));  // R1

endmodule

// File: rtl/tgs_group.sv
module tgs_group
    import tgs_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [SYNC_W-1:0]            sync_reg,
    input  logic [NUM_CH-1:0][SEL_W-1:0] sel_reg,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [NUM_CH-1:0]            cnt_en,
    input  logic [NUM_CH-1:0]            clr_evt,
    output cnt_cmd_t [NUM_CH-1:0]        cmd
);

    logic [NUM_CH-1:0] enrolled;
    logic [NUM_CH-1:0] member;
    logic [NUM_CH-1:0] own_clr;
    logic [NUM_CH-1:0] own_wr;
    logic              formed;
    logic              grp_clr;
    logic              grp_ld;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
        assign enrolled[c] = sync_reg[sync_pos(c)];
        assign own_clr[c]  = clr_evt[c] && (sel_reg[c] != '0);
        assign own_wr[c]   = wr_en && (wr_addr == ADDR_W'(c));
    end

    always_comb begin
        int unsigned n;
        n = 0;
        for (int c = 0; c < NUM_CH; c++) n += enrolled[c] ? 1 : 0;
        formed = (n >= 2);
    end

    assign member  = formed ? enrolled : '0;
    assign grp_clr = |(member & own_clr);
    assign grp_ld  = |(member & own_wr);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_cmd
        always_comb begin
            cmd[c].clr = own_clr[c] || (member[c] && grp_clr);
            cmd[c].ld  = !cmd[c].clr && (own_wr[c] || (member[c] && grp_ld));
            cmd[c].inc = !cmd[c].clr && !cmd[c].ld && cnt_en[c];
        end
    end

    AST_NO_LONE_MEMBER: assert property (@(posedge clk) disable iff (rst)
        $countones(member) != 1);  // R8

    AST_MEMBER_ENROLLED: assert property (@(posedge clk) disable iff (rst)
        (member & ~enrolled) == '0);  // R4

endmodule

// File: rtl/tgs_counter.sv
module tgs_counter
    import tgs_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_cmd_t         cmd,
    input  logic [CNT_W-1:0] ld_val,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst)          cnt <= '0;
        else if (cmd.clr) cnt <= '0;
        else if (cmd.ld)  cnt <= ld_val;
        else if (cmd.inc) cnt <= cnt + 1'b1;
    end

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        cmd.clr |=> cnt == '0);  // R9

    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
        (cmd.ld && !cmd.clr) |=> cnt == $past(ld_val));  // R5

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cmd.inc && !cmd.clr && !cmd.ld && cnt == TOP) |=> cnt == '0);  // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!cmd.clr && !cmd.ld && !cmd.inc) |=> $stable(cnt));  // R4

endmodule

// File: rtl/timer_sync_group.sv
module timer_sync_group
    import tgs_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SEL_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    input  logic [NUM_CH-1:0] cnt_en,
    input  logic [NUM_CH-1:0] clr_evt
);

    logic [SYNC_W-1:0]            sync_reg;
    logic [NUM_CH-1:0][SEL_W-1:0] sel_reg;
    cnt_cmd_t [NUM_CH-1:0]        cmd;
    logic [NUM_CH-1:0][CNT_W-1:0] cnt;

    tgs_regs #(.DATA_W(CNT_W), .SEL_W(SEL_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .sync_reg (sync_reg),
        .sel_reg  (sel_reg)
    );

    tgs_group #(.SEL_W(SEL_W)) u_group (
        .clk      (clk),
        .rst      (rst),
        .sync_reg (sync_reg),
        .sel_reg  (sel_reg),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .cnt_en   (cnt_en),
        .clr_evt  (clr_evt),
        .cmd      (cmd)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        tgs_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst    (rst),
            .cmd    (cmd[c]),
            .ld_val (wr_data),
            .cnt    (cnt[c])
        );
    end

    // R10: read map
    always_comb begin
        rd_data = '0;
        if (int'(rd_addr) < NUM_CH) begin
            rd_data = cnt[rd_addr[2:0]];
        end else if (int'(rd_addr) == ADDR_SYNC) begin
            rd_data[SYNC_W-1:0] = sync_reg;
        end else if (int'(rd_addr) < ADDR_SEL0 + NUM_CH) begin
            rd_data[SEL_W-1:0] = sel_reg[3'(int'(rd_addr) - ADDR_SEL0)];
        end
    end

endmodule

// File: tb/timer_sync_group_test.sv
`timescale 1ns/1ps
module timer_sync_group_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [4:0]  cnt_en = '0;
    logic [4:0]  clr_evt = '0;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    logic [15:0] m_cnt [5];
    logic [7:0]  m_sync;
    logic [2:0]  m_sel [5];

    timer_sync_group uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cnt_en(cnt_en), .clr_evt(clr_evt)
    );

    always #4 clk = ~clk;  // 125 MHz

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            done = 1;
            fails++; checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    function automatic bit m_enrolled(input int c);
        case (c)
            0: return m_sync[0];
            1: return m_sync[1];
            2: return m_sync[2];
            3: return m_sync[6];
            default: return m_sync[7];
        endcase
    endfunction

    function automatic logic [15:0] m_read(input int a);
        if (a < 5) return m_cnt[a];
        if (a == 5) return {8'h00, m_sync};
        if (a < 11) return {13'h0, m_sel[a-6]};
        return 16'h0;
    endfunction

    // Reference update from the requirements (R3..R9)
    task automatic model_step();
        int n;
        bit gclr, gld;
        bit mem [5];
        bit oclr [5];
        bit owr [5];
        n = 0;
        for (int c = 0; c < 5; c++) n += m_enrolled(c) ? 1 : 0;
        gclr = 0; gld = 0;
        for (int c = 0; c < 5; c++) begin
            mem[c]  = (n >= 2) && m_enrolled(c);
            oclr[c] = clr_evt[c] && (m_sel[c] != 3'b000);
            owr[c]  = wr_en && (int'(wr_addr) == c);
            if (mem[c] && oclr[c]) gclr = 1;
            if (mem[c] && owr[c])  gld = 1;
        end
        for (int c = 0; c < 5; c++) begin
            if (oclr[c] || (mem[c] && gclr))      m_cnt[c] = 16'h0;
            else if (owr[c] || (mem[c] && gld))   m_cnt[c] = wr_data;
            else if (cnt_en[c])                   m_cnt[c] = m_cnt[c] + 16'h1;
        end
        if (wr_en && wr_addr == 4'd5) m_sync = wr_data[7:0] & 8'hC7;
        if (wr_en && wr_addr >= 4'd6 && wr_addr <= 4'd10) m_sel[wr_addr-6] = wr_data[2:0];
    endtask

    task automatic check_all(input string tag);
        for (int a = 0; a < 12; a++) begin
            rd_addr = 4'(a);
            #0.2;
            checks++;
            if (rd_data !== m_read(a)) begin
                fails++;
                $display("FAIL %s addr=%0d: actual=%h expected=%h", tag, a, rd_data, m_read(a));
            end
        end
    endtask

    task automatic drive(input bit we, input int addr, input logic [15:0] d,
                         input logic [4:0] en, input logic [4:0] cl);
        wr_en = we; wr_addr = 4'(addr); wr_data = d; cnt_en = en; clr_evt = cl;
    endtask

    task automatic step(input string tag);
        model_step();
        @(posedge clk); #1;
        check_all(tag);
        @(negedge clk);
        drive(0, 0, 16'h0, 5'h0, 5'h0);
    endtask

    initial begin
        int seed;
        for (int c = 0; c < 5; c++) begin m_cnt[c] = '0; m_sel[c] = '0; end
        m_sync = '0;
        seed = $urandom(32'd20240607);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1 check_all("R1");

        // R2: reserved bits drop, mapping of channels 3,4 to bits 6,7
        drive(1, 5, 16'h00FF, 5'h0, 5'h0); step("R2");
        drive(1, 5, 16'h0000, 5'h0, 5'h0); step("R2");

        // R8: single enrolled channel stays independent
        drive(1, 5, 16'h0001, 5'h0, 5'h0); step("R8");
        drive(1, 0, 16'h1234, 5'h0, 5'h0); step("R8");
        drive(1, 1, 16'h0055, 5'h0, 5'h0); step("R10");

        // R5: group of ch0, ch1, ch3; write to ch3 spreads, ch2/ch4 untouched (R4)
        drive(1, 5, 16'h0043, 5'h0, 5'h0); step("R5");
        drive(1, 2, 16'h0777, 5'h0, 5'h0); step("R4");
        drive(1, 3, 16'hABCD, 5'h0, 5'h0); step("R5");

        // R6: ch1 selects clear, fires; ch0/ch3 (select 0) clear too
        drive(1, 7, 16'h0002, 5'h0, 5'h0); step("R6");
        drive(0, 0, 16'h0, 5'h0, 5'b00010); step("R6");

        // R7: ch2 select 0, clear event ignored while counting
        drive(0, 0, 16'h0, 5'b00100, 5'b00100); step("R7");
        // R7: member ch0 select 0 event does not clear group
        drive(1, 0, 16'h0101, 5'h0, 5'h0); step("R5");
        drive(0, 0, 16'h0, 5'h0, 5'b00001); step("R7");

        // R9: clear beats load on independent ch4
        drive(1, 10, 16'h0005, 5'h0, 5'h0); step("R9");
        drive(1, 4, 16'h4444, 5'h0, 5'h0); step("R9");
        drive(1, 4, 16'h9999, 5'h0, 5'b10000); step("R9");
        // R9: load beats increment
        drive(1, 2, 16'h2222, 5'b00100, 5'h0); step("R9");

        // R3: wrap on ch2
        drive(1, 2, 16'hFFFF, 5'h0, 5'h0); step("R3");
        drive(0, 0, 16'h0, 5'b00100, 5'h0); step("R3");
        drive(0, 0, 16'h0, 5'b00100, 5'h0); step("R3");

        // Random mixed traffic
        for (int i = 0; i < 3000; i++) begin
            int kind;
            logic [15:0] d;
            kind = $urandom_range(0, 9);
            d = 16'($urandom);
            if ($urandom_range(0, 3) == 0) d = 16'hFFFE + 16'($urandom_range(0, 1));
            case (kind)
                0, 1, 2: drive(1, $urandom_range(0, 4), d, 5'($urandom), 5'h0);
                3:       drive(1, 5, d, 5'($urandom), 5'h0);
                4:       drive(1, $urandom_range(6, 11), d, 5'($urandom), 5'h0);
                5, 6:    drive(1, $urandom_range(0, 4), d, 5'($urandom), 5'($urandom));
                default: drive(0, 0, d, 5'($urandom), 5'($urandom) & 5'($urandom));
            endcase
            step("R6");
        end

        // R1: reset again mid-run
        rst = 1'b1;
        @(posedge clk); #1;
        @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < 5; c++) begin m_cnt[c] = '0; m_sel[c] = '0; end
        m_sync = '0;
        #1 check_all("R1");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule